// File: doc/BRIEF.md
# Up/Down Timer with Per-Output Event Action Matrix

This block is a general-purpose timer for a larger chip. A counter runs either upward from zero to a programmable top value, or downward from the top value to zero. Two compare registers match against the counter, and two capture registers latch the counter when an edge arrives on an external input. Each of two output pins is driven by an action matrix. For every output, each of three event sources (end of count, compare 0 match, compare 1 match) has its own two-bit action: none, set, clear or toggle. A fixed precedence settles the case where two sources act in the same cycle.

Besides the pins, the block produces three further kinds of signal. It gives a one-cycle internal event pulse for other on-chip logic. It gives two DMA request pulses. It groups its five interrupt sources onto three pending lines, and a one-hot output names the line with the highest priority. When the DMA request of a source is enabled, that source no longer raises its interrupt. Software configures the block through a synchronous register bus with a write strobe and a combinational read port.

Top module: `cmp_act_timer`

## Requirements
- R1: When CTRL bit 0 (run) is 1 and CTRL bit 1 (down) is 0, the counter steps by one each cycle and, in the cycle it equals TOP, marks end of count and goes to 0. With down at 1 it steps down, and in the cycle it equals 0 it marks end of count and reloads TOP. With run at 0 it holds. A write to COUNT loads the counter in that cycle.
- R2: Each output has a 6-bit action field (ACT0 for out 0, ACT1 for out 1). Bits [1:0] belong to end of count, [3:2] to compare 0 and [5:4] to compare 1, with the encoding 00 none, 01 set, 10 clear, 11 toggle. The output takes its new value on the clock edge that ends the event cycle, and it holds its value when no event occurs.
- R3: When several sources with a non-none action fire in the same cycle, one action is applied. End of count wins over compare 0, and compare 0 wins over compare 1.
- R4: evt_o pulses in the cycle after an end of count when CTRL bit 4 is set. It also pulses in the cycle after a compare 0 match when CTRL bit 5 is set. No other source drives it.
- R5: A compare match fires in a cycle where run is 1 and the counter equals the compare register.
- R6: ICR gives each capture input two bits: input 0 uses bits [1:0] and input 1 uses bits [3:2]. The encoding is 00 off, 01 rising, 10 falling, 11 both. The input passes through a two-stage synchronizer. A selected edge latches the counter into CAP0 or CAP1, and an edge that is not selected leaves the register unchanged.
- R7: dma_req_o[0] pulses for one cycle on a capture into CAP0 when CTRL bit 2 is set. dma_req_o[1] pulses for one cycle on a compare 0 match when CTRL bit 3 is set. While a DMA request is enabled, its source does not set an interrupt.
- R8: IMASK enables each interrupt source: bit 0 end of count, bit 1 capture 0, bit 2 capture 1, bit 3 compare 0, bit 4 compare 1. An enabled source sets a pending line: line 0 for end of count, line 1 for either capture, line 2 for either compare. The lines drive irq_o. Writing 1 to a bit of IPEND clears that line, and a set in the same cycle wins over the clear.
- R9: irq_sel_o is one-hot on the lowest-numbered pending line, so line 0 has the highest priority. It is zero when no line is pending.
- R10: After reset, every output, the counter and all registers are zero.
- R11: The register addresses are 0 CTRL, 1 TOP, 2 CMP0, 3 CMP1, 4 CAP0, 5 CAP1, 6 ICR, 7 ACT0, 8 ACT1, 9 IMASK, 10 IPEND, 11 COUNT. rdata_o shows the register at addr_i in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | 4 | Register address |
| wdata_i | input | 16 | Write data |
| rdata_o | output | 16 | Read data for addr_i |
| cap_i | input | 2 | Capture inputs (asynchronous) |
| out_o | output | 2 | Action-driven output pins |
| evt_o | output | 1 | Internal on-chip event pulse |
| dma_req_o | output | 2 | DMA request pulses (capture 0, compare 0) |
| irq_o | output | 3 | Pending interrupt lines |
| irq_sel_o | output | 3 | One-hot highest-priority pending line |

## Verification
A counter state that has gone wrong first shows in the timing of the events. Within one period of TOP+1 cycles, out_o, evt_o and dma_req_o move a cycle early or late, and COUNT reads back a value the reference does not expect. An action or precedence error shows one edge after the event cycle, because out_o then holds the wrong level. A pending or steering error shows at once on irq_o and irq_sel_o, and it remains there until the next write-1 clear. The bench compares every output against its own reference model in every cycle. Random configurations, with small TOP values, make events dense and coincident.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  localparam int ADDR_W  = 4;
  localparam int N_CAP   = 2;
  localparam int N_OUT   = 2;
  localparam int N_CMP   = 2;
  localparam int N_DMA   = 2;
  localparam int N_LINE  = 3;
  localparam int N_SRC   = 3;            // end of count, cmp0, cmp1
  localparam int N_ISRC  = 5;            // eoc, cap0, cap1, cmp0, cmp1
  localparam int ACT_W   = 2 * N_SRC;
  localparam int ICR_W   = 2 * N_CAP;
  localparam int CTRL_W  = 6;

  typedef enum logic [1:0] {
    ACT_NONE = 2'b00,
    ACT_SET  = 2'b01,
    ACT_CLR  = 2'b10,
    ACT_TGL  = 2'b11
  } act_e;

  localparam int C_RUN     = 0;
  localparam int C_DOWN    = 1;
  localparam int C_DMA_CAP = 2;
  localparam int C_DMA_CMP = 3;
  localparam int C_EVT_EOC = 4;
  localparam int C_EVT_CMP = 5;

  localparam logic [ADDR_W-1:0] A_CTRL  = 4'd0;
  localparam logic [ADDR_W-1:0] A_TOP   = 4'd1;
  localparam logic [ADDR_W-1:0] A_CMP0  = 4'd2;
  localparam logic [ADDR_W-1:0] A_CMP1  = 4'd3;
  localparam logic [ADDR_W-1:0] A_CAP0  = 4'd4;
  localparam logic [ADDR_W-1:0] A_CAP1  = 4'd5;
  localparam logic [ADDR_W-1:0] A_ICR   = 4'd6;
  localparam logic [ADDR_W-1:0] A_ACT0  = 4'd7;
  localparam logic [ADDR_W-1:0] A_ACT1  = 4'd8;
  localparam logic [ADDR_W-1:0] A_IMASK = 4'd9;
  localparam logic [ADDR_W-1:0] A_IPEND = 4'd10;
  localparam logic [ADDR_W-1:0] A_COUNT = 4'd11;
endpackage

// File: rtl/tmr_counter.sv
module tmr_counter import tmr_pkg::*; #(
  parameter int CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic             down_i,
  input  logic [CNT_W-1:0] top_i,
  input  logic [CNT_W-1:0] cmp_i [N_CMP],
  input  logic             ld_i,
  input  logic [CNT_W-1:0] ld_val_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             eoc_o,
  output logic [N_CMP-1:0] match_o
);
  logic [CNT_W-1:0] cnt_q, cnt_d;

  assign eoc_o = run_i && (down_i ? (cnt_q == '0) : (cnt_q == top_i));

  for (genvar k = 0; k < N_CMP; k++) begin : g_cmp
    assign match_o[k] = run_i && (cnt_q == cmp_i[k]);
  end

  always_comb begin
    if (ld_i)        cnt_d = ld_val_i;
    else if (!run_i) cnt_d = cnt_q;
    else if (eoc_o)  cnt_d = down_i ? top_i : '0;
    else if (down_i) cnt_d = cnt_q - 1'b1;
    else             cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else         cnt_q <= cnt_d;
  end

  assign cnt_o = cnt_q;
endmodule

// File: rtl/tmr_capture.sv
module tmr_capture #(
  parameter int CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             pin_i,
  input  logic [1:0]       mode_i,   // [0] rising, [1] falling
  input  logic [CNT_W-1:0] cnt_i,
  output logic             hit_o,
  output logic [CNT_W-1:0] val_o
);
  logic s1_q, s2_q, s3_q;
  logic [CNT_W-1:0] val_q;
  logic rise, fall;

  assign rise  = s2_q & ~s3_q;
  assign fall  = ~s2_q & s3_q;
  assign hit_o = (mode_i[0] & rise) | (mode_i[1] & fall);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_q  <= 1'b0;
      s2_q  <= 1'b0;
      s3_q  <= 1'b0;
      val_q <= '0;
    end else begin
      s1_q <= pin_i;
      s2_q <= s1_q;
      s3_q <= s2_q;
      if (hit_o) val_q <= cnt_i;
    end
  end

  assign val_o = val_q;
endmodule

// File: rtl/tmr_out_action.sv
module tmr_out_action import tmr_pkg::*; (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [ACT_W-1:0] act_i,
  input  logic [N_SRC-1:0] ev_i,   // index 0 has highest precedence
  output logic             out_o
);
  act_e sel;
  logic out_q, out_d;

  always_comb begin
    sel = ACT_NONE;
    for (int s = N_SRC - 1; s >= 0; s--) begin
      if (ev_i[s] && (act_e'(act_i[2*s +: 2]) != ACT_NONE)) sel = act_e'(act_i[2*s +: 2]);
    end
  end

  always_comb begin
    unique case (sel)
      ACT_SET: out_d = 1'b1;
      ACT_CLR: out_d = 1'b0;
      ACT_TGL: out_d = ~out_q;
      default: out_d = out_q;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) out_q <= 1'b0;
    else         out_q <= out_d;
  end

  assign out_o = out_q;
endmodule

// File: rtl/tmr_irq.sv
module tmr_irq import tmr_pkg::*; (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [N_ISRC-1:0] src_i,    // eoc, cap0, cap1, cmp0, cmp1
  input  logic [N_ISRC-1:0] mask_i,
  input  logic [N_DMA-1:0]  dma_en_i, // [0] cap0, [1] cmp0
  input  logic [N_LINE-1:0] clr_i,
  output logic [N_LINE-1:0] pend_o,
  output logic [N_LINE-1:0] sel_o,
  output logic [N_DMA-1:0]  dma_o
);
  logic [N_ISRC-1:0] steal, eff;
  logic [N_LINE-1:0] set, pend_q;
  logic [N_DMA-1:0]  dma_q;

  always_comb begin
    steal    = '0;
    steal[1] = src_i[1] & dma_en_i[0];
    steal[3] = src_i[3] & dma_en_i[1];
    eff      = src_i & mask_i & ~steal;
    set[0]   = eff[0];
    set[1]   = eff[1] | eff[2];
    set[2]   = eff[3] | eff[4];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q <= '0;
      dma_q  <= '0;
    end else begin
      pend_q <= (pend_q & ~clr_i) | set;
      dma_q  <= {steal[3], steal[1]};
    end
  end

  assign pend_o = pend_q;
  assign sel_o  = pend_q & (~pend_q + 1'b1);
  assign dma_o  = dma_q;
endmodule

// File: rtl/cmp_act_timer.sv
module cmp_act_timer import tmr_pkg::*; #(
  parameter int CNT_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [CNT_W-1:0]  wdata_i,
  output logic [CNT_W-1:0]  rdata_o,
  input  logic [N_CAP-1:0]  cap_i,
  output logic [N_OUT-1:0]  out_o,
  output logic              evt_o,
  output logic [N_DMA-1:0]  dma_req_o,
  output logic [N_LINE-1:0] irq_o,
  output logic [N_LINE-1:0] irq_sel_o
);
  logic [CTRL_W-1:0] ctrl_q;
  logic [CNT_W-1:0]  top_q;
  logic [CNT_W-1:0]  cmp_q [N_CMP];
  logic [ICR_W-1:0]  icr_q;
  logic [ACT_W-1:0]  act_q [N_OUT];
  logic [N_ISRC-1:0] imask_q;

  logic [CNT_W-1:0]  cnt;
  logic              ev_eoc, ev_m0, ev_m1;
  logic [N_CMP-1:0]  match;
  logic [N_CAP-1:0]  cap_hit;
  logic [CNT_W-1:0]  cap_val [N_CAP];
  logic [N_LINE-1:0] clr;
  logic              evt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q  <= '0;
      top_q   <= '0;
      icr_q   <= '0;
      imask_q <= '0;
      for (int i = 0; i < N_CMP; i++) cmp_q[i] <= '0;
      for (int i = 0; i < N_OUT; i++) act_q[i] <= '0;
    end else if (wr_en_i) begin
      unique case (addr_i)
        A_CTRL:  ctrl_q   <= wdata_i[CTRL_W-1:0];
        A_TOP:   top_q    <= wdata_i;
        A_CMP0:  cmp_q[0] <= wdata_i;
        A_CMP1:  cmp_q[1] <= wdata_i;
        A_ICR:   icr_q    <= wdata_i[ICR_W-1:0];
        A_ACT0:  act_q[0] <= wdata_i[ACT_W-1:0];
        A_ACT1:  act_q[1] <= wdata_i[ACT_W-1:0];
        A_IMASK: imask_q  <= wdata_i[N_ISRC-1:0];
        default: ;
      endcase
    end
  end

  tmr_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .run_i    (ctrl_q[C_RUN]),
    .down_i   (ctrl_q[C_DOWN]),
    .top_i    (top_q),
    .cmp_i    (cmp_q),
    .ld_i     (wr_en_i && (addr_i == A_COUNT)),
    .ld_val_i (wdata_i),
    .cnt_o    (cnt),
    .eoc_o    (ev_eoc),
    .match_o  (match)
  );

  assign ev_m0 = match[0];
  assign ev_m1 = match[1];

  for (genvar c = 0; c < N_CAP; c++) begin : g_cap
    tmr_capture #(.CNT_W(CNT_W)) u_cap (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .pin_i  (cap_i[c]),
      .mode_i (icr_q[2*c +: 2]),
      .cnt_i  (cnt),
      .hit_o  (cap_hit[c]),
      .val_o  (cap_val[c])
    );
  end

  for (genvar o = 0; o < N_OUT; o++) begin : g_out
    tmr_out_action u_act (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .act_i  (act_q[o]),
      .ev_i   ({ev_m1, ev_m0, ev_eoc}),
      .out_o  (out_o[o])
    );
  end

  assign clr = (wr_en_i && (addr_i == A_IPEND)) ? wdata_i[N_LINE-1:0] : '0;

  tmr_irq u_irq (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .src_i    ({ev_m1, ev_m0, cap_hit[1], cap_hit[0], ev_eoc}),
    .mask_i   (imask_q),
    .dma_en_i ({ctrl_q[C_DMA_CMP], ctrl_q[C_DMA_CAP]}),
    .clr_i    (clr),
    .pend_o   (irq_o),
    .sel_o    (irq_sel_o),
    .dma_o    (dma_req_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) evt_q <= 1'b0;
    else         evt_q <= (ev_eoc & ctrl_q[C_EVT_EOC]) | (ev_m0 & ctrl_q[C_EVT_CMP]);
  end
  assign evt_o = evt_q;

  always_comb begin
    unique case (addr_i)
      A_CTRL:  rdata_o = CNT_W'(ctrl_q);
      A_TOP:   rdata_o = top_q;
      A_CMP0:  rdata_o = cmp_q[0];
      A_CMP1:  rdata_o = cmp_q[1];
      A_CAP0:  rdata_o = cap_val[0];
      A_CAP1:  rdata_o = cap_val[1];
      A_ICR:   rdata_o = CNT_W'(icr_q);
      A_ACT0:  rdata_o = CNT_W'(act_q[0]);
      A_ACT1:  rdata_o = CNT_W'(act_q[1]);
      A_IMASK: rdata_o = CNT_W'(imask_q);
      A_IPEND: rdata_o = CNT_W'(irq_o);
      A_COUNT: rdata_o = cnt;
      default: rdata_o = '0;
    endcase
  end
endmodule

// File: rtl/tmr_checker.sv
module tmr_checker import tmr_pkg::*; (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [N_OUT-1:0]  out_o,
  input logic              evt_o,
  input logic [N_DMA-1:0]  dma_req_o,
  input logic [N_LINE-1:0] irq_o,
  input logic [N_LINE-1:0] irq_sel_o,
  input logic              ev_eoc,
  input logic              ev_m0,
  input logic              ev_m1
);
  AST_OUT_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(ev_eoc || ev_m0 || ev_m1) |=> $stable(out_o)); // R2
  AST_EVT_SOURCE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    evt_o |-> $past(ev_eoc || ev_m0)); // R4
  AST_DMA_CMP_SOURCE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dma_req_o[1] |-> $past(ev_m0)); // R7
  AST_SEL_ONEHOT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(irq_sel_o)); // R9
  AST_SEL_PENDING: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_sel_o & ~irq_o) == '0); // R9
  AST_SEL_LINE0_FIRST: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o[0] |-> irq_sel_o[0]); // R9
  AST_SEL_NONEMPTY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_o != '0) |-> (irq_sel_o != '0)); // R9
endmodule

bind cmp_act_timer tmr_checker u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .out_o     (out_o),
  .evt_o     (evt_o),
  .dma_req_o (dma_req_o),
  .irq_o     (irq_o),
  .irq_sel_o (irq_sel_o),
  .ev_eoc    (ev_eoc),
  .ev_m0     (ev_m0),
  .ev_m1     (ev_m1)
);

// File: tb/cmp_act_timer_tb.sv
module cmp_act_timer_tb;
  localparam int CLK_PERIOD = 10;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        wr_en_i = 1'b0;
  logic [3:0]  addr_i = '0;
  logic [15:0] wdata_i = '0;
  logic [15:0] rdata_o;
  logic [1:0]  cap_i = '0;
  logic [1:0]  out_o;
  logic        evt_o;
  logic [1:0]  dma_req_o;
  logic [2:0]  irq_o;
  logic [2:0]  irq_sel_o;

  cmp_act_timer u_dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .wr_en_i(wr_en_i), .addr_i(addr_i),
    .wdata_i(wdata_i), .rdata_o(rdata_o), .cap_i(cap_i), .out_o(out_o),
    .evt_o(evt_o), .dma_req_o(dma_req_o), .irq_o(irq_o), .irq_sel_o(irq_sel_o)
  );

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;

  // mirrored registers
  logic [5:0]  r_ctrl = '0;
  logic [15:0] r_top = '0, r_cmp0 = '0, r_cmp1 = '0;
  logic [3:0]  r_icr = '0;
  logic [5:0]  r_act0 = '0, r_act1 = '0;
  logic [4:0]  r_imask = '0;
  // reference model state
  logic [15:0] m_cnt = '0, m_cap0 = '0, m_cap1 = '0;
  logic [1:0]  m_out = '0, m_dma = '0, m_s1 = '0, m_s2 = '0, m_s3 = '0;
  logic        m_evt = 0;
  logic [2:0]  m_pend = '0;
  logic [1:0]  cap_drv = '0;

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic logic apply_act(logic cur, logic [5:0] f, logic e_eoc, logic e0, logic e1);
    logic [1:0] a;
    a = 2'b00;
    if (e_eoc && f[1:0] != 2'b00)   a = f[1:0];
    else if (e0 && f[3:2] != 2'b00) a = f[3:2];
    else if (e1 && f[5:4] != 2'b00) a = f[5:4];
    case (a)
      2'b01:   return 1'b1;
      2'b10:   return 1'b0;
      2'b11:   return ~cur;
      default: return cur;
    endcase
  endfunction

  function automatic logic [2:0] exp_sel(logic [2:0] p);
    if (p[0]) return 3'b001;
    if (p[1]) return 3'b010;
    if (p[2]) return 3'b100;
    return 3'b000;
  endfunction

  task automatic compare_outputs();
    chk(out_o == m_out, "R2,R3", "out_o", out_o, m_out);
    chk(evt_o == m_evt, "R4", "evt_o", evt_o, m_evt);
    chk(dma_req_o == m_dma, "R7", "dma_req_o", dma_req_o, m_dma);
    chk(irq_o == m_pend, "R8", "irq_o", irq_o, m_pend);
    chk(irq_sel_o == exp_sel(m_pend), "R9", "irq_sel_o", irq_sel_o, exp_sel(m_pend));
  endtask

  // one clock cycle; entered and left at a falling edge
  task automatic cycle(input bit we, input logic [3:0] a, input logic [15:0] d);
    logic run, dn, eoc, e0, e1;
    logic [15:0] n_cnt, n_cap0, n_cap1;
    logic [1:0] hit, n_out, n_dma;
    logic [2:0] set, clr, n_pend;
    logic n_evt;
    wr_en_i = we; addr_i = a; wdata_i = d; cap_i = cap_drv;
    run = r_ctrl[0]; dn = r_ctrl[1];
    eoc = run && (dn ? (m_cnt == 16'd0) : (m_cnt == r_top));
    e0  = run && (m_cnt == r_cmp0);
    e1  = run && (m_cnt == r_cmp1);
    if (!run)      n_cnt = m_cnt;
    else if (eoc)  n_cnt = dn ? r_top : 16'd0;
    else if (dn)   n_cnt = m_cnt - 16'd1;
    else           n_cnt = m_cnt + 16'd1;
    if (we && a == 4'd11) n_cnt = d;
    for (int c = 0; c < 2; c++)
      hit[c] = (r_icr[2*c] && m_s2[c] && !m_s3[c]) || (r_icr[2*c+1] && !m_s2[c] && m_s3[c]);
    n_cap0 = hit[0] ? m_cnt : m_cap0;
    n_cap1 = hit[1] ? m_cnt : m_cap1;
    n_out[0] = apply_act(m_out[0], r_act0, eoc, e0, e1);
    n_out[1] = apply_act(m_out[1], r_act1, eoc, e0, e1);
    n_evt = (eoc && r_ctrl[4]) || (e0 && r_ctrl[5]);
    n_dma = {e0 && r_ctrl[3], hit[0] && r_ctrl[2]};
    set[0] = eoc && r_imask[0];
    set[1] = (hit[0] && r_imask[1] && !r_ctrl[2]) || (hit[1] && r_imask[2]);
    set[2] = (e0 && r_imask[3] && !r_ctrl[3]) || (e1 && r_imask[4]);
    clr = (we && a == 4'd10) ? d[2:0] : 3'b000;
    n_pend = (m_pend & ~clr) | set;
    @(posedge clk_i);
    m_cnt = n_cnt; m_cap0 = n_cap0; m_cap1 = n_cap1; m_out = n_out;
    m_evt = n_evt; m_dma = n_dma; m_pend = n_pend;
    m_s3 = m_s2; m_s2 = m_s1; m_s1 = cap_drv;
    if (we) begin
      case (a)
        4'd0: r_ctrl = d[5:0];
        4'd1: r_top = d;
        4'd2: r_cmp0 = d;
        4'd3: r_cmp1 = d;
        4'd6: r_icr = d[3:0];
        4'd7: r_act0 = d[5:0];
        4'd8: r_act1 = d[5:0];
        4'd9: r_imask = d[4:0];
        default: ;
      endcase
    end
    @(negedge clk_i);
    wr_en_i = 1'b0;
    compare_outputs();
  endtask

  task automatic wr(input logic [3:0] a, input logic [15:0] d);
    cycle(1'b1, a, d);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) cycle(1'b0, 4'd0, 16'd0);
  endtask

  task automatic rd_chk(input logic [3:0] a, input logic [15:0] exp, input string req);
    addr_i = a;
    #1;
    chk(rdata_o == exp, req, $sformatf("rdata@%0d", a), rdata_o, exp);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    // R10: reset state
    compare_outputs();
    rd_chk(4'd11, 16'd0, "R10");
    rd_chk(4'd0, 16'd0, "R10");
    rd_chk(4'd7, 16'd0, "R10");

    // R11: register readback
    wr(4'd1, 16'd5);
    wr(4'd2, 16'd2);
    wr(4'd3, 16'd4);
    wr(4'd7, 16'b01_10_01);      // eoc set, cmp0 clear, cmp1 set
    wr(4'd8, 16'b11_00_11);      // eoc toggle, cmp1 toggle
    wr(4'd9, 16'h1f);
    rd_chk(4'd1, 16'd5, "R11");
    rd_chk(4'd2, 16'd2, "R11");
    rd_chk(4'd7, 16'b01_10_01, "R11");
    rd_chk(4'd9, 16'h1f, "R11");

    // R1/R2/R5: up count with events; R4 eoc and cmp0 event pulses
    wr(4'd0, 16'b11_0001);
    idle(20);
    rd_chk(4'd11, m_cnt, "R1");
    // R3: cmp0 coincides with eoc, eoc action wins
    wr(4'd2, 16'd5);
    idle(14);
    // R1: down count
    wr(4'd0, 16'b01_0011);
    idle(15);
    rd_chk(4'd11, m_cnt, "R1");
    // R8: write-1 clear of pending lines
    wr(4'd0, 16'd0);
    wr(4'd10, 16'h7);
    chk(irq_o == 3'b000, "R8", "irq_o after clear", irq_o, 0);

    // R6: capture, rising on input 0, falling only on input 1
    wr(4'd11, 16'h1234);
    wr(4'd6, 16'b10_01);
    cap_drv = 2'b11;
    idle(4);
    rd_chk(4'd4, 16'h1234, "R6");
    rd_chk(4'd5, 16'h0000, "R6");  // rising edge ignored on input 1
    chk(irq_o[1] == 1'b1, "R6", "capture pending", irq_o[1], 1);
    wr(4'd10, 16'h7);
    wr(4'd11, 16'h0abc);
    cap_drv = 2'b00;
    idle(4);
    rd_chk(4'd4, 16'h1234, "R6");  // falling edge ignored on input 0
    rd_chk(4'd5, 16'h0abc, "R6");

    // R7: DMA on capture 0 steals its interrupt
    wr(4'd10, 16'h7);
    wr(4'd0, 16'b00_0100);
    wr(4'd11, 16'h0055);
    wr(4'd6, 16'b00_01);
    cap_drv = 2'b01;
    idle(5);
    chk(irq_o[1] == 1'b0, "R7", "capture irq stolen by dma", irq_o[1], 0);
    rd_chk(4'd4, 16'h0055, "R7");
    cap_drv = 2'b00;
    idle(3);

    // random rounds
    for (int r = 0; r < 60; r++) begin
      logic [15:0] top;
      top = 16'($urandom_range(0, 12));
      wr(4'd0, 16'd0);
      wr(4'd1, top);
      wr(4'd2, 16'($urandom_range(0, int'(top) + 2)));
      wr(4'd3, 16'($urandom_range(0, int'(top) + 2)));
      wr(4'd7, 16'($urandom_range(0, 63)));
      wr(4'd8, 16'($urandom_range(0, 63)));
      wr(4'd9, 16'($urandom_range(0, 31)));
      wr(4'd6, 16'($urandom_range(0, 15)));
      wr(4'd11, 16'($urandom_range(0, int'(top))));
      wr(4'd0, 16'($urandom_range(0, 63)) | 16'd1);
      for (int i = 0; i < 80; i++) begin
        if ($urandom_range(0, 3) == 0) cap_drv = 2'($urandom_range(0, 3));
        if ($urandom_range(0, 9) == 0) wr(4'd10, 16'($urandom_range(0, 7)));
        else cycle(1'b0, 4'd0, 16'd0);
        if (i % 16 == 15) begin
          rd_chk(4'd11, m_cnt, "R1");
          rd_chk(4'd4, m_cap0, "R6");
          rd_chk(4'd5, m_cap1, "R6");
          rd_chk(4'd10, 16'(m_pend), "R8");
        end
      end
    end

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end
endmodule